// File: doc/BRIEF.md
# Seconds Countdown Alarm with Interrupt and Wake Outputs

This block is a seconds-remaining alarm. Software writes a number of seconds into a 32-bit counter register and sets the count-enable bit. After that, each one-second tick pulse lowers the counter by one. When a tick takes the counter from one to zero, the block latches a pending flag. The counter then stays at zero until software writes a new value.

The pending flag drives two outputs. Each output has its own enable bit. One output is an interrupt line for the processor. The other is a wake request for the power controller. Software acknowledges an expiry by writing a one to the pending bit.

To re-arm the alarm, software first writes zero to the counter, waits briefly, and then writes the new count. The block accepts this sequence at any time, and the zero write never counts as an expiry. Access is through a simple single-cycle write strobe with a combinational read path.

Top module: `secs_alarm`

## Requirements
- R1: After reset, the counter, the count enable, the interrupt enable, the wake enable and the pending flag all read as zero, and both outputs are low.
- R2: A write to offset 0x20 loads the full 32-bit counter. A read of 0x20 returns the current count.
- R3: The counter drops by exactly one on a cycle with tick high only when count enable (bit 0 at 0x28) is 1 and the count is nonzero. Otherwise the counter holds its value.
- R4: A tick that takes the count from 1 to 0 sets the pending flag (bit 0 at 0x30) on that same clock edge. After that the count stays at zero and later ticks never set the flag again.
- R5: Writing zero to the counter does not set the pending flag. A nonzero value written afterwards counts down and expires normally.
- R6: Writing 1 to bit 0 at 0x30 clears the pending flag. Writing 0 to that bit leaves the flag unchanged.
- R7: When an expiry and a clearing write to 0x30 fall in the same cycle, the pending flag ends up set.
- R8: irqOut is high exactly when the pending flag and interrupt enable (bit 0 at 0x2C) are both 1.
- R9: wakeOut is high exactly when the pending flag and wake enable (bit 0 at 0x50) are both 1.
- R10: A counter write in the same cycle as an enabled tick loads the written value with no decrement.
- R11: The enable registers keep only bit 0; their other bits read 0. Offsets outside 0x20, 0x28, 0x2C, 0x30 and 0x50 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| irqOut | output | 1 | Interrupt request |
| wakeOut | output | 1 | Wake request |

## Verification
Two pairs of events can coincide.

The first pair is the final tick that expires the count and a write-one-to-clear of the pending bit. The bench drives both in the same cycle. It expects the flag to read back set, with the enabled output high.

The second pair is an enabled tick and a counter write. The bench raises both together and expects the written value to read back without a decrement.

// File: rtl/secs_alarm_pkg.sv
package secs_alarm_pkg;
  // Register offsets; software depends on these positions.
  localparam int unsigned OFS_COUNT = 32'h20;
  localparam int unsigned OFS_RUN   = 32'h28;
  localparam int unsigned OFS_IRQEN = 32'h2C;
  localparam int unsigned OFS_PEND  = 32'h30;
  localparam int unsigned OFS_WAKE  = 32'h50;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadCnt;
    logic stepCnt;
  } cnt_strobe_t;
endpackage

// File: rtl/secs_alarm_dp.sv
module secs_alarm_dp
  import secs_alarm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      stb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cntValue,
  output logic             cntIsZero,
  output logic             cntIsOne
);
  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (stb.loadCnt) begin
      countQ <= loadVal;
    end else if (stb.stepCnt) begin
      countQ <= countQ - CNT_W'(1);
    end
  end

  assign cntValue  = countQ;
  assign cntIsZero = (countQ == '0);
  assign cntIsOne  = (countQ == CNT_W'(1));
endmodule

// File: rtl/secs_alarm_ctrl.sv
module secs_alarm_ctrl
  import secs_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wBit0,
  input  logic              cntIsZero,
  input  logic              cntIsOne,
  output cnt_strobe_t       stb,
  output logic              cntEn,
  output logic              irqEn,
  output logic              wakeEn,
  output logic              pending
);
  logic wrCount, wrRun, wrIrqEn, wrPend, wrWake;
  logic expire, clrPend;

  always_comb begin
    wrCount = regWe && (regAddr == ADDR_W'(OFS_COUNT));
    wrRun   = regWe && (regAddr == ADDR_W'(OFS_RUN));
    wrIrqEn = regWe && (regAddr == ADDR_W'(OFS_IRQEN));
    wrPend  = regWe && (regAddr == ADDR_W'(OFS_PEND));
    wrWake  = regWe && (regAddr == ADDR_W'(OFS_WAKE));
    stb.loadCnt = wrCount;
    stb.stepCnt = tick && cntEn && !cntIsZero && !wrCount;
    expire  = stb.stepCnt && cntIsOne;
    clrPend = wrPend && wBit0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntEn   <= 1'b0;
      irqEn   <= 1'b0;
      wakeEn  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (wrRun)   cntEn  <= wBit0;
      if (wrIrqEn) irqEn  <= wBit0;
      if (wrWake)  wakeEn <= wBit0;
      // A set wins over a same-cycle clear.
      if (expire)       pending <= 1'b1;
      else if (clrPend) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/secs_alarm.sv
module secs_alarm
  import secs_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut,
  output logic              wakeOut
);
  cnt_strobe_t      stb;
  logic [CNT_W-1:0] cntValue;
  logic             cntIsZero, cntIsOne;
  logic             cntEn, irqEn, wakeEn, pending;

  secs_alarm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .regWe(regWe), .regAddr(regAddr),
    .wBit0(regWdata[0]), .cntIsZero(cntIsZero), .cntIsOne(cntIsOne),
    .stb(stb), .cntEn(cntEn), .irqEn(irqEn), .wakeEn(wakeEn), .pending(pending)
  );

  secs_alarm_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(regWdata[CNT_W-1:0]),
    .cntValue(cntValue), .cntIsZero(cntIsZero), .cntIsOne(cntIsOne)
  );

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(OFS_COUNT))      regRdata = DATA_W'(cntValue);
    else if (regAddr == ADDR_W'(OFS_RUN))   regRdata = DATA_W'(cntEn);
    else if (regAddr == ADDR_W'(OFS_IRQEN)) regRdata = DATA_W'(irqEn);
    else if (regAddr == ADDR_W'(OFS_PEND))  regRdata = DATA_W'(pending);
    else if (regAddr == ADDR_W'(OFS_WAKE))  regRdata = DATA_W'(wakeEn);
  end

  assign irqOut  = pending && irqEn;
  assign wakeOut = pending && wakeEn;
endmodule

// File: rtl/secs_alarm_chk.sv
module secs_alarm_chk
  import secs_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [CNT_W-1:0]  cntValue,
  input logic              cntEn,
  input logic              pending
);
  logic wrCnt, clrWr, lastTick;
  assign wrCnt    = regWe && (regAddr == ADDR_W'(OFS_COUNT));
  assign clrWr    = regWe && (regAddr == ADDR_W'(OFS_PEND)) && regWdata[0];
  assign lastTick = tick && cntEn && !wrCnt && (cntValue == CNT_W'(1));

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !wrCnt) |=> $stable(cntValue));

  // R3
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntEn && !wrCnt && cntValue != '0) |=> (cntValue == $past(cntValue) - CNT_W'(1)));

  // R4
  expiry_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastTick |=> pending);

  // R4
  pend_rise_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> (cntValue == '0));

  // R5
  zero_load_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCnt && regWdata[CNT_W-1:0] == '0 && !pending) |=> !pending);

  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !lastTick) |=> !pending);

  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && lastTick) |=> pending);

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt |=> (cntValue == $past(regWdata[CNT_W-1:0])));
endmodule

bind secs_alarm secs_alarm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .cntValue(cntValue), .cntEn(cntEn), .pending(pending)
);

// File: tb/sim_secs_alarm.sv
`timescale 1ns/1ps
module sim_secs_alarm;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut, wakeOut;
  int          nChecks = 0;
  int          nErrors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  secs_alarm u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut), .wakeOut(wakeOut)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic withTick = 1'b0);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d; tick = withTick;
    @(negedge clk);
    regWe = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h20, d); chk("R1 count", d, 0);
    rd(8'h28, d); chk("R1 run", d, 0);
    rd(8'h2C, d); chk("R1 irqEn", d, 0);
    rd(8'h30, d); chk("R1 pend", d, 0);
    rd(8'h50, d); chk("R1 wake", d, 0);
    chk("R1 outs", {30'd0, irqOut, wakeOut}, 0);
  endtask

  task automatic t_load();
    logic [31:0] d;
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); chk("R2 full", d, 32'hFFFF_FFFF);
    wr(8'h20, 32'hA5A5_1234); rd(8'h20, d); chk("R2 mixed", d, 32'hA5A5_1234);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    wr(8'h28, 0); wr(8'h20, 5); ticks(3);
    rd(8'h20, d); chk("R3 disabled hold", d, 5);
    wr(8'h28, 1); repeat (6) @(negedge clk);
    rd(8'h20, d); chk("R3 no tick hold", d, 5);
    ticks(2); rd(8'h20, d); chk("R3 two steps", d, 3);
  endtask

  task automatic t_expire();
    logic [31:0] d;
    wr(8'h2C, 1); wr(8'h50, 0); wr(8'h20, 3); ticks(2);
    rd(8'h30, d); chk("R4 not yet", d, 0);
    chk("R8 irq low", {31'd0, irqOut}, 0);
    ticks(1);
    rd(8'h20, d); chk("R4 at zero", d, 0);
    rd(8'h30, d); chk("R4 pend set", d, 1);
    chk("R8 irq high", {31'd0, irqOut}, 1);
    chk("R9 wake off", {31'd0, wakeOut}, 0);
    wr(8'h30, 1); rd(8'h30, d); chk("R6 cleared", d, 0);
    ticks(4);
    rd(8'h20, d); chk("R4 stays zero", d, 0);
    rd(8'h30, d); chk("R4 no reset", d, 0);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    wr(8'h2C, 0); wr(8'h50, 1); wr(8'h20, 1); ticks(1);
    chk("R9 wake high", {31'd0, wakeOut}, 1);
    chk("R8 irq masked", {31'd0, irqOut}, 0);
    wr(8'h30, 32'hFFFF_FFFE); rd(8'h30, d); chk("R6 zero bit no effect", d, 1);
    wr(8'h30, 1);
    chk("R9 wake drops", {31'd0, wakeOut}, 0);
  endtask

  task automatic t_reload();
    logic [31:0] d;
    wr(8'h20, 0); rd(8'h30, d); chk("R5 zero write quiet", d, 0);
    wr(8'h20, 2); ticks(1); rd(8'h30, d); chk("R5 mid", d, 0);
    ticks(1); rd(8'h30, d); chk("R5 reload expires", d, 1);
    wr(8'h30, 1);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(8'h2C, 1); wr(8'h20, 1);
    wr(8'h30, 1, 1'b1);
    rd(8'h30, d); chk("R7 set wins", d, 1);
    chk("R7 irq high", {31'd0, irqOut}, 1);
    wr(8'h30, 1); rd(8'h30, d); chk("R7 later clear", d, 0);
  endtask

  task automatic t_tickwrite();
    logic [31:0] d;
    wr(8'h20, 10); wr(8'h20, 7, 1'b1);
    rd(8'h20, d); chk("R10 load wins", d, 7);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, d); chk("R11 run bit0 only", d, 1);
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h24, 32'h1234_5678);
    rd(8'h40, d); chk("R11 hole 0x40", d, 0);
    rd(8'h24, d); chk("R11 hole 0x24", d, 0);
    rd(8'h20, d); chk("R11 count kept", d, 7);
    rd(8'h30, d); chk("R11 pend kept", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_load();
    t_gate();
    t_expire();
    t_wake();
    t_reload();
    t_collide();
    t_tickwrite();
    t_unmapped();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end
endmodule